// File: doc/BRIEF.md
# UART Transmit Gating and DTR Pin Controller

This block sits between a UART's transmit FIFO and its serializer. It decides, at each character boundary, whether the serializer may begin a new character, and it drives the active-low DTR# pin. Grants are one-cycle pulses. An in-band flow-control character may be sent even while normal data is held. Normal data is held by a software transmit-off bit. When DSR gating is enabled, a high (inactive) DSR# input also holds normal data.

DTR# has four functions, chosen by a two-bit mode:
- a plain software-controlled modem line;
- receive-side flow control, with hysteresis between an upper and a lower FIFO-level threshold;
- an RS485 line-driver enable, in either polarity, that follows the transmitter-empty status.

Two override selects can replace all of these with the transmitter 1x clock or the Nx baud clock. The serializer, the FIFOs and the baud generator are outside this block.

Top module: `uart_tx_dtr_ctrl`

## Requirements
- R1: While reset is held, `data_go` and `flow_go` are 0 and DTR# is low when no clock override is selected.
- R2: `data_go` is high in the cycle after a cycle in which `char_boundary`, `fifo_nonempty` and the other gating terms all permit a start; otherwise it is low.
- R3: When `tx_off_req` is 1 in the boundary cycle, normal data is held. The bit is looked at only in boundary cycles, so toggling it while a character is in flight has no effect.
- R4: A pending in-band flow character (`flow_char_pend`=1) is granted through `flow_go` at a boundary even when transmit-off or DSR gating holds data. It also wins over normal data, and the two grants are never high together.
- R5: With `dsr_gate_en`=1, `dsr_n`=1 blocks `data_go`. With `dsr_gate_en`=0, `dsr_n` has no effect.
- R6: Each grant lasts exactly one cycle. No grant is issued in the cycle right after a grant, even if `char_boundary` stays high.
- R7: In mode 2'b00, DTR# equals the inverse of `sw_dtr`, one cycle after the input.
- R8: In mode 2'b01, DTR# goes high one cycle after `rx_level` >= `thr_hi`.
- R9: In mode 2'b01, DTR# returns low one cycle after `rx_level` < `thr_lo`. For a level in the range `thr_lo` <= level < `thr_hi`, DTR# keeps its previous value.
- R10: In mode 2'b10, DTR# equals `tx_empty` one cycle later, so it is low while sending. In mode 2'b11, DTR# equals the inverse of `tx_empty`.
- R11: `clk1x_sel`=1 puts `clk1x` on DTR# without delay. Otherwise `clknx_sel`=1 puts `clknx` there. Either select overrides the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_boundary | input | 1 | Serializer idle, ready for a new character |
| fifo_nonempty | input | 1 | Transmit FIFO holds data |
| flow_char_pend | input | 1 | In-band flow character waiting |
| tx_off_req | input | 1 | Software transmit-off bit |
| dsr_gate_en | input | 1 | Enable DSR-based transmit gating |
| dsr_n | input | 1 | DSR# input, active low |
| dtr_mode | input | 2 | DTR# function select |
| sw_dtr | input | 1 | Software DTR bit (1 = assert, pin low) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper flow threshold |
| thr_lo | input | LVL_W | Lower flow threshold |
| tx_empty | input | 1 | Transmitter fully empty, line idle |
| clk1x_sel | input | 1 | Put 1x transmit clock on DTR# |
| clknx_sel | input | 1 | Put Nx baud clock on DTR# |
| clk1x | input | 1 | Transmitter 1x clock |
| clknx | input | 1 | Baud generator Nx clock |
| data_go | output | 1 | Start-normal-character pulse |
| flow_go | output | 1 | Start-flow-character pulse |
| dtr_n | output | 1 | DTR# pin |

## Verification
Start gating is tried under three kinds of pattern, and each one separates a different gating term:
- one term at a time is withdrawn at a boundary;
- transmit-off is toggled while no boundary is present;
- data and a flow character are made to compete.

A boundary held high for several cycles shows the one-cycle pulse spacing. The receive-level sweep walks up to the upper threshold, back through the band and down through the lower threshold. This separates true hysteresis from a single comparison. Both RS485 polarities and both clock selects, alone and together, show the polarity and the override order.

// File: rtl/uart_dtr_pkg.sv
// Package: shared encodings for the transmit gating and DTR controller.
package uart_dtr_pkg;
    typedef enum logic [1:0] {
        DTR_LEGACY   = 2'b00,
        DTR_RXFLOW   = 2'b01,
        DTR_RS485_LO = 2'b10,
        DTR_RS485_HI = 2'b11
    } dtr_mode_e;
endpackage

// File: rtl/uart_txgate.sv
// Module: uart_txgate
// Issues one-cycle start pulses to the serializer. A flow character wins
// over data and ignores transmit-off and DSR gating. Data needs a
// non-empty FIFO, transmit-off clear and DSR permission. Assumes the
// serializer drops char_boundary soon after a pulse. The cycle after a
// pulse never grants, which keeps pulses one cycle wide.
module uart_txgate (
    input  logic clk,
    input  logic rst_n,
    input  logic char_boundary,
    input  logic fifo_nonempty,
    input  logic flow_char_pend,
    input  logic tx_off_req,
    input  logic dsr_gate_en,
    input  logic dsr_n,
    output logic data_go,
    output logic flow_go
);
    logic dsr_ok;
    logic recent_go;
    logic flow_d;
    logic data_d;

    // DSR permission: gating off, or DSR# asserted low.
    always_comb dsr_ok = ~dsr_gate_en | ~dsr_n;

    // A grant in the previous cycle blocks a fresh one.
    always_comb recent_go = data_go | flow_go;

    // Start decisions for the coming cycle, flow character first.
    always_comb begin
        flow_d = char_boundary & ~recent_go & flow_char_pend;
        data_d = char_boundary & ~recent_go & ~flow_char_pend
               & fifo_nonempty & ~tx_off_req & dsr_ok;
    end

    // Register the start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_go <= 1'b0;
            flow_go <= 1'b0;
        end else begin
            data_go <= data_d;
            flow_go <= flow_d;
        end
    end
endmodule

// File: rtl/uart_rxlvl_hyst.sv
// Module: uart_rxlvl_hyst
// Receive-level flow state with hysteresis. It sets at or above the upper
// threshold, clears strictly below the lower one and holds in between.
// Assumes thr_lo <= thr_hi. It tracks the level in every mode so that the
// state is current when the mode is switched.
module uart_rxlvl_hyst #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    output logic             stop_d,
    output logic             stop_q
);
    logic at_hi;
    logic below_lo;

    // Threshold comparisons.
    always_comb begin
        at_hi    = (rx_level >= thr_hi);
        below_lo = (rx_level < thr_lo);
    end

    // Next stop state: set wins, then clear, else hold.
    always_comb begin
        if (at_hi)         stop_d = 1'b1;
        else if (below_lo) stop_d = 1'b0;
        else               stop_d = stop_q;
    end

    // Hold the stop state; reset means not stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_d;
    end
endmodule

// File: rtl/uart_dtr_mux.sv
// Module: uart_dtr_mux
// Forms the DTR# pin. A registered base value follows the two-bit mode.
// The clock overrides then act without delay, 1x before Nx. Assumes the
// clock inputs are already in this clock domain or that glitches on a
// clock output are acceptable.
module uart_dtr_mux
    import uart_dtr_pkg::*;
#(
    parameter bit CLK_OVR_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  dtr_mode_e mode,
    input  logic      sw_dtr,
    input  logic      flow_stop,
    input  logic      tx_empty,
    input  logic      clk1x_sel,
    input  logic      clknx_sel,
    input  logic      clk1x,
    input  logic      clknx,
    output logic      dtr_n
);
    logic base_d;
    logic base_q;

    // Pin level chosen by the mode.
    always_comb begin
        unique case (mode)
            DTR_LEGACY:   base_d = ~sw_dtr;
            DTR_RXFLOW:   base_d = flow_stop;
            DTR_RS485_LO: base_d = tx_empty;
            DTR_RS485_HI: base_d = ~tx_empty;
            default:      base_d = 1'b0;
        endcase
    end

    // Register the mode level; reset drives the pin active low.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= 1'b0;
        else        base_q <= base_d;
    end

    generate
        if (CLK_OVR_EN) begin : g_ovr
            // Clock overrides with 1x first.
            always_comb begin
                if (clk1x_sel)      dtr_n = clk1x;
                else if (clknx_sel) dtr_n = clknx;
                else                dtr_n = base_q;
            end
        end else begin : g_no_ovr
            logic unused_ovr;
            // Overrides compiled out.
            always_comb unused_ovr = clk1x_sel ^ clknx_sel ^ clk1x ^ clknx;
            always_comb dtr_n = base_q;
        end
    endgenerate
endmodule

// File: rtl/uart_tx_dtr_ctrl.sv
// Module: uart_tx_dtr_ctrl (top)
// Transmit start gating and DTR# pin control for one UART channel.
// Assumes tx_empty is already qualified by the line being back at idle.
module uart_tx_dtr_ctrl
    import uart_dtr_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_boundary,
    input  logic             fifo_nonempty,
    input  logic             flow_char_pend,
    input  logic             tx_off_req,
    input  logic             dsr_gate_en,
    input  logic             dsr_n,
    input  logic [1:0]       dtr_mode,
    input  logic             sw_dtr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             tx_empty,
    input  logic             clk1x_sel,
    input  logic             clknx_sel,
    input  logic             clk1x,
    input  logic             clknx,
    output logic             data_go,
    output logic             flow_go,
    output logic             dtr_n
);
    logic      stop_d;
    logic      stop_q;
    dtr_mode_e mode_e;

    // Decode the mode field into the shared type.
    always_comb mode_e = dtr_mode_e'(dtr_mode);

    uart_txgate u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .char_boundary  (char_boundary),
        .fifo_nonempty  (fifo_nonempty),
        .flow_char_pend (flow_char_pend),
        .tx_off_req     (tx_off_req),
        .dsr_gate_en    (dsr_gate_en),
        .dsr_n          (dsr_n),
        .data_go        (data_go),
        .flow_go        (flow_go)
    );

    uart_rxlvl_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .stop_d   (stop_d),
        .stop_q   (stop_q)
    );

    uart_dtr_mux #(.CLK_OVR_EN(1'b1)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .sw_dtr    (sw_dtr),
        .flow_stop (stop_d),
        .tx_empty  (tx_empty),
        .clk1x_sel (clk1x_sel),
        .clknx_sel (clknx_sel),
        .clk1x     (clk1x),
        .clknx     (clknx),
        .dtr_n     (dtr_n)
    );
endmodule

// File: rtl/uart_tx_dtr_chk.sv
// Checker for uart_tx_dtr_ctrl, attached by bind below.
module uart_tx_dtr_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             char_boundary,
    input logic             fifo_nonempty,
    input logic             flow_char_pend,
    input logic             tx_off_req,
    input logic             dsr_gate_en,
    input logic             dsr_n,
    input logic [1:0]       dtr_mode,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] thr_hi,
    input logic             tx_empty,
    input logic             clk1x_sel,
    input logic             clknx_sel,
    input logic             clk1x,
    input logic             data_go,
    input logic             flow_go,
    input logic             dtr_n
);
    a_r2_grant_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> $past(char_boundary && fifo_nonempty && !tx_off_req));

    a_r4_flow_first: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> !$past(flow_char_pend));

    a_r4_no_dual_grant: assert property (@(posedge clk) disable iff (!rst_n)
        flow_go |-> !data_go);

    a_r5_dsr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> $past(!dsr_gate_en || !dsr_n));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (data_go || flow_go) |=> !(data_go || flow_go));

    a_r8_high_level_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dtr_mode) == 2'b01 && $past(rx_level >= thr_hi)
         && !clk1x_sel && !clknx_sel) |-> dtr_n);

    a_r10_rs485_low_active: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dtr_mode) == 2'b10 && !clk1x_sel && !clknx_sel)
        |-> (dtr_n == $past(tx_empty)));

    a_r11_1x_override: assert property (@(posedge clk) disable iff (!rst_n)
        clk1x_sel |-> (dtr_n == clk1x));
endmodule

bind uart_tx_dtr_ctrl uart_tx_dtr_chk #(.LVL_W(LVL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .char_boundary  (char_boundary),
    .fifo_nonempty  (fifo_nonempty),
    .flow_char_pend (flow_char_pend),
    .tx_off_req     (tx_off_req),
    .dsr_gate_en    (dsr_gate_en),
    .dsr_n          (dsr_n),
    .dtr_mode       (dtr_mode),
    .rx_level       (rx_level),
    .thr_hi         (thr_hi),
    .tx_empty       (tx_empty),
    .clk1x_sel      (clk1x_sel),
    .clknx_sel      (clknx_sel),
    .clk1x          (clk1x),
    .data_go        (data_go),
    .flow_go        (flow_go),
    .dtr_n          (dtr_n)
);

// File: tb/sim_uart_tx_dtr_ctrl.sv
// Directed bench: one task per scenario; inputs change 1 ns after a rising
// edge and outputs are sampled 1 ns after the following edge.
module sim_uart_tx_dtr_ctrl;
    localparam int LVL_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_boundary = 1'b0, fifo_nonempty = 1'b0, flow_char_pend = 1'b0;
    logic tx_off_req = 1'b0, dsr_gate_en = 1'b0, dsr_n = 1'b0;
    logic [1:0] dtr_mode = 2'b00;
    logic sw_dtr = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, thr_hi = 8'd100, thr_lo = 8'd20;
    logic tx_empty = 1'b1, clk1x_sel = 1'b0, clknx_sel = 1'b0;
    logic clk1x = 1'b0, clknx = 1'b0;
    logic data_go, flow_go, dtr_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_tx_dtr_ctrl #(.LVL_W(LVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .char_boundary(char_boundary),
        .fifo_nonempty(fifo_nonempty), .flow_char_pend(flow_char_pend),
        .tx_off_req(tx_off_req), .dsr_gate_en(dsr_gate_en), .dsr_n(dsr_n),
        .dtr_mode(dtr_mode), .sw_dtr(sw_dtr), .rx_level(rx_level),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .tx_empty(tx_empty),
        .clk1x_sel(clk1x_sel), .clknx_sel(clknx_sel), .clk1x(clk1x),
        .clknx(clknx), .data_go(data_go), .flow_go(flow_go), .dtr_n(dtr_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic quiet();
        char_boundary = 0; fifo_nonempty = 0; flow_char_pend = 0;
        tx_off_req = 0; dsr_gate_en = 0; dsr_n = 0;
        tick(); tick();
    endtask

    task automatic t_reset();
        char_boundary = 1; fifo_nonempty = 1; sw_dtr = 0;
        tick(); tick();
        check("R1 data_go in reset", data_go, 1'b0);
        check("R1 flow_go in reset", flow_go, 1'b0);
        check("R1 dtr_n in reset", dtr_n, 1'b0);
        char_boundary = 0; fifo_nonempty = 0;
        rst_n = 1;
        tick();
    endtask

    task automatic t_grant();
        quiet();
        char_boundary = 1; fifo_nonempty = 1;
        tick(); check("R2 grant at boundary", data_go, 1'b1);
        tick(); check("R6 no back-to-back grant", data_go, 1'b0);
        tick(); check("R6 grant again after gap", data_go, 1'b1);
        fifo_nonempty = 0;
        tick(); tick(); check("R2 empty FIFO holds", data_go, 1'b0);
        fifo_nonempty = 1; char_boundary = 0;
        tick(); tick(); check("R2 no boundary holds", data_go, 1'b0);
    endtask

    task automatic t_disable();
        quiet();
        fifo_nonempty = 1; tx_off_req = 1;
        tick(); tx_off_req = 0; tick();
        char_boundary = 1;
        tick(); check("R3 mid-char toggle ignored", data_go, 1'b1);
        quiet();
        fifo_nonempty = 1; tx_off_req = 1; char_boundary = 1;
        tick(); tick(); check("R3 transmit-off holds data", data_go, 1'b0);
    endtask

    task automatic t_flow();
        quiet();
        tx_off_req = 1; fifo_nonempty = 1; flow_char_pend = 1; char_boundary = 1;
        tick();
        check("R4 flow char while off", flow_go, 1'b1);
        check("R4 data held while off", data_go, 1'b0);
        quiet();
        fifo_nonempty = 1; flow_char_pend = 1; char_boundary = 1;
        tick();
        check("R4 flow char wins", flow_go, 1'b1);
        check("R4 data loses", data_go, 1'b0);
        quiet();
        dsr_gate_en = 1; dsr_n = 1; flow_char_pend = 1; char_boundary = 1;
        tick();
        check("R4 flow char ignores DSR", flow_go, 1'b1);
    endtask

    task automatic t_dsr();
        quiet();
        dsr_gate_en = 1; dsr_n = 1; fifo_nonempty = 1; char_boundary = 1;
        tick(); tick(); check("R5 DSR inactive blocks", data_go, 1'b0);
        dsr_n = 0;
        tick(); check("R5 DSR active permits", data_go, 1'b1);
        quiet();
        dsr_gate_en = 0; dsr_n = 1; fifo_nonempty = 1; char_boundary = 1;
        tick(); check("R5 gating off ignores DSR", data_go, 1'b1);
    endtask

    task automatic t_legacy();
        dtr_mode = 2'b00; sw_dtr = 1;
        tick(); check("R7 sw_dtr=1 pin low", dtr_n, 1'b0);
        sw_dtr = 0;
        tick(); check("R7 sw_dtr=0 pin high", dtr_n, 1'b1);
    endtask

    task automatic t_hyst();
        rx_level = 8'd0; dtr_mode = 2'b01;
        tick(); check("R9 low level pin low", dtr_n, 1'b0);
        rx_level = 8'd99;
        tick(); check("R9 in band from low holds low", dtr_n, 1'b0);
        rx_level = 8'd100;
        tick(); check("R8 upper threshold pin high", dtr_n, 1'b1);
        rx_level = 8'd50;
        tick(); check("R9 in band holds high", dtr_n, 1'b1);
        rx_level = 8'd20;
        tick(); check("R9 at lower threshold holds high", dtr_n, 1'b1);
        rx_level = 8'd19;
        tick(); check("R9 below lower threshold pin low", dtr_n, 1'b0);
        rx_level = 8'd0;
    endtask

    task automatic t_rs485();
        dtr_mode = 2'b10; tx_empty = 0;
        tick(); check("R10 mode10 busy pin low", dtr_n, 1'b0);
        tx_empty = 1;
        tick(); check("R10 mode10 empty pin high", dtr_n, 1'b1);
        dtr_mode = 2'b11;
        tick(); check("R10 mode11 empty pin low", dtr_n, 1'b0);
        tx_empty = 0;
        tick(); check("R10 mode11 busy pin high", dtr_n, 1'b1);
        tx_empty = 1;
    endtask

    task automatic t_override();
        dtr_mode = 2'b11; tx_empty = 0; tick();
        clknx_sel = 1; clknx = 0; #1;
        check("R11 Nx clock low", dtr_n, 1'b0);
        clknx = 1; #1;
        check("R11 Nx clock high", dtr_n, 1'b1);
        clk1x_sel = 1; clk1x = 0; #1;
        check("R11 1x wins over Nx", dtr_n, 1'b0);
        clk1x = 1; clknx = 0; #1;
        check("R11 1x follows", dtr_n, 1'b1);
        clk1x_sel = 0; clknx_sel = 0; #1;
        check("R11 release to mode", dtr_n, 1'b1);
        tx_empty = 1;
    endtask

    initial begin
        t_reset();
        t_grant();
        t_disable();
        t_flow();
        t_dsr();
        quiet();
        t_legacy();
        t_hyst();
        t_rs485();
        t_override();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule